// File: doc/BRIEF.md
# Clock Switch Control and Status Register

This block holds the software-visible control and status state for a clock-source switching unit. Software picks a next clock source with a 2-bit code and raises a switch request. An external switch state machine, which is not part of this block, carries out the switch and reports the outcome with single-cycle pulses. Each pulse drops the request. The block also keeps a PLL lock flag and a clock-fail flag. Each flag has its own set and clear sources, and the priority between them is fixed.

The block also supplies a 4-bit trim value for the internal fast RC oscillator. Eight 4-bit trim fields are stored in two trim words. In fixed mode the output is always field 0. In sequenced mode an external 3-bit rolling index selects the field, and the index is registered inside the block. A dither-enable bit is held as a plain control bit.

All registers are read through a combinational read port. Writes go through a write port and take effect at the next clock edge.

Top module: `csw_ctrl`

## Requirements
- R1: A synchronous reset clears every stored bit. After reset the control word reads 0, both trim words read 0, and switch_req, clk_fail, lock_status, dither_en and trim_out are all 0.
- R2: The control word is at address 0 and has this layout:
  - bit 0: switch request
  - bits 2:1: next-source code
  - bit 3: dither enable
  - bit 4: sequencer enable
  - bit 5: clock-fail flag
  - bit 6: lock flag
  - bits 15:7: always read 0

  Writes to bits 15:7 and to bit 6 have no effect, and writing 1 to bit 5 has no effect. Address 3 always reads 0, and writes to it change nothing.
- R3: A control write with bit 0 = 1 sets switch_req at the next edge, and a write with bit 0 = 0 leaves it unchanged. A pulse on sw_done, sw_redundant or sw_failsafe clears switch_req at the next edge.
- R4: When a control write setting bit 0 falls in the same cycle as a request-clearing pulse, the request stays set.
- R5: The lock flag is loaded each cycle with pll_locked, except that a sw_start pulse forces it to 0. lock_status and bit 6 show the flag ANDed with pll_selected, without delay.
- R6: A fail_detect pulse sets the clock-fail flag at the next edge. The flag is cleared by a sw_start pulse or by a control write with bit 5 = 0.
- R7: A fail_detect pulse wins over a software clear or a sw_start in the same cycle.
- R8: The dither enable is a plain read/write bit and is driven out on dither_en.
- R9: The eight trim fields are stored as follows:
  - fields 0 to 3 at address 1, fields 4 to 7 at address 2
  - within each word, the k-th field of that word sits at bits 4k+3:4k

  Both words read back as written.
- R10: With the sequencer enable at 0, trim_out equals field 0 whatever the rolling index.
- R11: With the sequencer enable at 1, trim_out equals the field chosen by roll_idx, and it changes one clock edge after roll_idx changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pll_locked | input | 1 | PLL lock indication |
| pll_selected | input | 1 | PLL is the selected system clock group |
| fail_detect | input | 1 | Clock-failure detect pulse |
| sw_start | input | 1 | Valid switch sequence started |
| sw_done | input | 1 | Switch completed |
| sw_redundant | input | 1 | Switch to the already-active source |
| sw_failsafe | input | 1 | Fail-safe forced switch to internal RC |
| roll_idx | input | ROLL_W | Rolling trim index |
| switch_req | output | 1 | Switch request |
| next_src | output | 2 | Requested next-source code |
| dither_en | output | 1 | Clock dither enable |
| clk_fail | output | 1 | Clock-fail flag |
| lock_status | output | 1 | Gated lock flag |
| trim_out | output | TRIM_W | Selected oscillator trim |

## Verification
The bench builds the block with its default parameters: a 3-bit rolling index, 4-bit trim fields and two trim words. That configuration is small enough to sweep completely.

The sweeps cover:
- all sixteen trim values shifted across all eight fields, in both trim modes and at every index;
- every combination of next-source code, dither bit and sequencer bit;
- each pair of conflicting set and clear events on the request and the fail flag, applied in the same cycle.

// File: rtl/csw_pkg.sv
package csw_pkg;

    localparam int REG_W = 16;
    localparam int SRC_W = 2;

    localparam int BIT_REQ    = 0;
    localparam int BIT_SRC    = 1;
    localparam int BIT_DITHER = 3;
    localparam int BIT_SEQ    = 4;
    localparam int BIT_FAIL   = 5;
    localparam int BIT_LOCK   = 6;

    typedef struct packed {
        logic             req;
        logic [SRC_W-1:0] src;
        logic             dither;
        logic             seq_en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic done;
        logic redundant;
        logic failsafe;
    } sw_evt_t;

    function automatic ctrl_t unpack_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.req    = w[BIT_REQ];
        c.src    = w[BIT_SRC +: SRC_W];
        c.dither = w[BIT_DITHER];
        c.seq_en = w[BIT_SEQ];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(ctrl_t c, logic fail, logic lock);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[BIT_REQ]         = c.req;
        w[BIT_SRC +: SRC_W] = c.src;
        w[BIT_DITHER]      = c.dither;
        w[BIT_SEQ]         = c.seq_en;
        w[BIT_FAIL]        = fail;
        w[BIT_LOCK]        = lock;
        return w;
    endfunction

    function automatic logic req_clear(sw_evt_t e);
        return e.done | e.redundant | e.failsafe;
    endfunction

endpackage

// File: rtl/csw_status.sv
module csw_status (
    input  logic clk,
    input  logic rst,
    input  logic pll_locked,
    input  logic pll_selected,
    input  logic fail_detect,
    input  logic sw_start,
    input  logic sw_fail_clr,
    output logic lock_rd,
    output logic fail_q
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (sw_start) lock_q <= 1'b0;
            else          lock_q <= pll_locked;

            if (fail_detect)                   fail_q <= 1'b1;
            else if (sw_start || sw_fail_clr) fail_q <= 1'b0;
        end
    end

    assign lock_rd = lock_q & pll_selected;

    p_lock_start_r5: assert property (@(posedge clk) disable iff (rst)
        sw_start |=> !lock_q);
    p_lock_lost_r5: assert property (@(posedge clk) disable iff (rst)
        !pll_locked |=> !lock_q);
    p_fail_set_r7: assert property (@(posedge clk) disable iff (rst)
        fail_detect |=> fail_q);
    p_fail_clear_src_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(fail_q) |-> $past(sw_start || sw_fail_clr));

endmodule

// File: rtl/csw_switch_req.sv
module csw_switch_req
    import csw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_ctrl,
    input  ctrl_t   wr_val,
    input  sw_evt_t evt,
    output ctrl_t   ctrl_q
);
    logic clr;
    assign clr = req_clear(evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.src    <= wr_val.src;
                ctrl_q.dither <= wr_val.dither;
                ctrl_q.seq_en <= wr_val.seq_en;
            end
            if (wr_ctrl && wr_val.req) ctrl_q.req <= 1'b1;
            else if (clr)              ctrl_q.req <= 1'b0;
        end
    end

    p_req_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (clr && !(wr_ctrl && wr_val.req)) |=> !ctrl_q.req);
    p_req_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.req) |-> $past(wr_ctrl && wr_val.req));
    p_req_setwin_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_val.req) |=> ctrl_q.req);

endmodule

// File: rtl/csw_trim.sv
module csw_trim #(
    parameter int TRIM_W = 4,
    parameter int ROLL_W = 3,
    parameter int REG_W  = 16,
    parameter int WORDS  = 2,
    parameter int WSEL_W = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [WSEL_W-1:0]         wr_word,
    input  logic [REG_W-1:0]          wr_data,
    input  logic                      seq_en,
    input  logic [ROLL_W-1:0]         roll_idx,
    output logic [WORDS*REG_W-1:0]    trim_flat,
    output logic [TRIM_W-1:0]         trim_out
);
    logic [ROLL_W-1:0] roll_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trim_flat <= '0;
            roll_q    <= '0;
        end else begin
            roll_q <= roll_idx;
            for (int k = 0; k < WORDS; k++) begin
                if (wr_en && wr_word == WSEL_W'(k))
                    trim_flat[k*REG_W +: REG_W] <= wr_data;
            end
        end
    end

    always_comb begin
        if (seq_en) trim_out = trim_flat[roll_q*TRIM_W +: TRIM_W];
        else        trim_out = trim_flat[0 +: TRIM_W];
    end

    p_roll_lag_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> roll_q == $past(roll_idx));

endmodule

// File: rtl/csw_ctrl.sv
module csw_ctrl
    import csw_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int TRIM_W = 4,
    parameter int ROLL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    input  logic              pll_locked,
    input  logic              pll_selected,
    input  logic              fail_detect,
    input  logic              sw_start,
    input  logic              sw_done,
    input  logic              sw_redundant,
    input  logic              sw_failsafe,
    input  logic [ROLL_W-1:0] roll_idx,
    output logic              switch_req,
    output logic [1:0]        next_src,
    output logic              dither_en,
    output logic              clk_fail,
    output logic              lock_status,
    output logic [TRIM_W-1:0] trim_out
);
    localparam int N_TRIM = 1 << ROLL_W;
    localparam int WORDS  = (N_TRIM * TRIM_W) / REG_W;
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic    wr_ctrl, wr_trim, fail_clr;
    logic [WSEL_W-1:0]       trim_word;
    logic [WORDS*REG_W-1:0]  trim_flat;
    ctrl_t   wr_val, ctrl_q;
    sw_evt_t evt;

    assign wr_ctrl   = wr_en && (wr_addr == '0);
    assign wr_trim   = wr_en && (wr_addr != '0) && (wr_addr <= ADDR_W'(WORDS));
    assign trim_word = WSEL_W'(wr_addr - ADDR_W'(1));
    assign wr_val    = unpack_ctrl(wr_data);
    assign fail_clr  = wr_ctrl && !wr_data[BIT_FAIL];
    assign evt       = '{start: sw_start, done: sw_done,
                         redundant: sw_redundant, failsafe: sw_failsafe};

    csw_switch_req u_req (
        .clk    (clk),
        .rst    (rst),
        .wr_ctrl(wr_ctrl),
        .wr_val (wr_val),
        .evt    (evt),
        .ctrl_q (ctrl_q)
    );

    csw_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .pll_locked  (pll_locked),
        .pll_selected(pll_selected),
        .fail_detect (fail_detect),
        .sw_start    (sw_start),
        .sw_fail_clr (fail_clr),
        .lock_rd     (lock_status),
        .fail_q      (clk_fail)
    );

    csw_trim #(
        .TRIM_W(TRIM_W),
        .ROLL_W(ROLL_W),
        .REG_W (REG_W),
        .WORDS (WORDS),
        .WSEL_W(WSEL_W)
    ) u_trim (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_trim),
        .wr_word  (trim_word),
        .wr_data  (wr_data),
        .seq_en   (ctrl_q.seq_en),
        .roll_idx (roll_idx),
        .trim_flat(trim_flat),
        .trim_out (trim_out)
    );

    assign switch_req = ctrl_q.req;
    assign next_src   = ctrl_q.src;
    assign dither_en  = ctrl_q.dither;

    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = pack_ctrl(ctrl_q, clk_fail, lock_status);
        for (int k = 0; k < WORDS; k++) begin
            if (rd_addr == ADDR_W'(k + 1)) rd_data = trim_flat[k*REG_W +: REG_W];
        end
    end

    p_lock_gate_r5: assert property (@(posedge clk) disable iff (rst)
        !pll_selected |-> !rd_data[BIT_LOCK] || rd_addr != '0);
    p_src_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(next_src));

endmodule

// File: tb/csw_ctrl_test.sv
module csw_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst, wr_en, pll_locked, pll_selected, fail_detect;
    logic        sw_start, sw_done, sw_redundant, sw_failsafe;
    logic [1:0]  wr_addr, rd_addr, next_src;
    logic [15:0] wr_data, rd_data;
    logic [2:0]  roll_idx;
    logic        switch_req, dither_en, clk_fail, lock_status;
    logic [3:0]  trim_out;

    int n_chk = 0;
    int n_fail = 0;

    csw_ctrl uut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r;
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        pll_locked = 0; pll_selected = 0; fail_detect = 0;
        sw_start = 0; sw_done = 0; sw_redundant = 0; sw_failsafe = 0; roll_idx = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, r); check("R1 ctrl", r, 0);
        rd(1, r); check("R1 trim lo", r, 0);
        rd(2, r); check("R1 trim hi", r, 0);
        check("R1 outputs", {switch_req, clk_fail, lock_status, dither_en, trim_out}, 0);

        // R2 / R8 layout and reserved bits
        wr(0, 16'hFFFE);
        rd(0, r); check("R2 reserved bits", r, 16'h001E);
        check("R2 next_src", next_src, 3);
        check("R8 dither set", dither_en, 1);
        check("R2 no request", switch_req, 0);
        for (int v = 0; v < 16; v++) begin
            wr(0, 16'(v << 1));
            rd(0, r); check("R2 sweep", r, 32'(v << 1));
            check("R8 dither", dither_en, 32'((v >> 2) & 1));
        end
        wr(1, 16'h1234);
        wr(3, 16'hFFFF);
        rd(3, r); check("R2 addr3 reads 0", r, 0);
        rd(1, r); check("R2 addr3 write ignored", r, 16'h1234);
        rd(0, r); check("R2 addr3 write ctrl", r, 16'h001E);

        // R3 request set and clears
        wr(0, 16'h0005);
        check("R3 set", switch_req, 1);
        check("R3 src", next_src, 2);
        wr(0, 16'h0004);
        check("R3 write 0 ignored", switch_req, 1);
        repeat (3) @(negedge clk);
        check("R3 hold", switch_req, 1);
        sw_done = 1; @(negedge clk); sw_done = 0;
        check("R3 done clears", switch_req, 0);
        wr(0, 16'h0001);
        sw_redundant = 1; @(negedge clk); sw_redundant = 0;
        check("R3 redundant clears", switch_req, 0);
        wr(0, 16'h0001);
        sw_failsafe = 1; @(negedge clk); sw_failsafe = 0;
        check("R3 failsafe clears", switch_req, 0);

        // R4 set wins over concurrent clear
        sw_done = 1; wr(0, 16'h0001); sw_done = 0;
        check("R4 set wins", switch_req, 1);
        sw_failsafe = 1; @(negedge clk); sw_failsafe = 0;
        check("R4 cleared after", switch_req, 0);

        // R5 lock flag
        pll_selected = 1; pll_locked = 1; @(negedge clk);
        check("R5 lock", lock_status, 1);
        rd(0, r); check("R5 lock bit6", r[6], 1);
        pll_selected = 0; #1;
        check("R5 gated", lock_status, 0);
        rd(0, r); check("R5 gated bit6", r[6], 0);
        pll_selected = 1; #1;
        check("R5 ungated", lock_status, 1);
        sw_start = 1; @(negedge clk); sw_start = 0;
        check("R5 start clears", lock_status, 0);
        @(negedge clk);
        check("R5 relock", lock_status, 1);
        wr(0, 16'h0040);
        check("R2 lock write ignored", lock_status, 1);
        pll_locked = 0; #1;
        check("R5 before edge", lock_status, 1);
        @(negedge clk);
        check("R5 lost", lock_status, 0);

        // R6 / R7 fail flag
        fail_detect = 1; @(negedge clk); fail_detect = 0;
        check("R6 set", clk_fail, 1);
        wr(0, 16'h0020);
        check("R6 write 1 no effect", clk_fail, 1);
        wr(0, 16'h0000);
        check("R6 sw clear", clk_fail, 0);
        wr(0, 16'h0020);
        check("R2 write 1 fail bit", clk_fail, 0);
        fail_detect = 1; @(negedge clk); fail_detect = 0;
        sw_start = 1; @(negedge clk); sw_start = 0;
        check("R6 start clears", clk_fail, 0);
        fail_detect = 1; wr(0, 16'h0000); fail_detect = 0;
        check("R7 set beats sw clear", clk_fail, 1);
        fail_detect = 1; sw_start = 1; @(negedge clk); fail_detect = 0; sw_start = 0;
        check("R7 set beats start", clk_fail, 1);
        wr(0, 16'h0000);

        // R9 / R10 / R11 trim sweep
        for (int v = 0; v < 16; v++) begin
            logic [15:0] lo, hi;
            for (int f = 0; f < 4; f++) begin
                lo[f*4 +: 4] = 4'((v + f) % 16);
                hi[f*4 +: 4] = 4'((v + f + 4) % 16);
            end
            wr(1, lo); wr(2, hi);
            rd(1, r); check("R9 word lo", r, lo);
            rd(2, r); check("R9 word hi", r, hi);
            wr(0, 16'h0000);
            for (int i = 0; i < 8; i++) begin
                roll_idx = 3'(i); @(negedge clk);
                check("R10 base only", trim_out, 32'(v));
            end
            wr(0, 16'h0010);
            for (int i = 0; i < 8; i++) begin
                roll_idx = 3'(i); @(negedge clk);
                check("R11 sequenced", trim_out, 32'((v + i) % 16));
            end
        end
        roll_idx = 3'd5; #1;
        check("R11 lag before edge", trim_out, 32'(15 + 7) % 16);
        @(negedge clk);
        check("R11 after edge", trim_out, 32'((15 + 5) % 16));

        // R1 reset after activity
        wr(0, 16'h001F);
        fail_detect = 1; @(negedge clk); fail_detect = 0;
        rst = 1; @(negedge clk); rst = 0;
        rd(0, r); check("R1 ctrl after reset", r, 0);
        rd(2, r); check("R1 trim after reset", r, 0);
        check("R1 flags after reset", {switch_req, clk_fail, trim_out}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule